// File: doc/BRIEF.md
# Absolute Difference Execution Unit

This block is a 64-bit integer execution slice. It takes one 32-bit instruction word and the two operand values that were already read from the register file. It recognises the absolute-difference instruction and returns three things: the destination register index, the two source register indices, and the magnitude of the difference between the operands. The operands are ordered by a two's-complement comparison. The result is built as the one's complement of the smaller operand, plus the larger operand, plus one, and is kept to the operand width.

When the instruction's record bit is set, the unit also produces a 4-bit condition field and raises a write enable for it. The field holds three flags from a signed test of the result against zero, followed by a copy of the summary-overflow input. The same primary opcode also carries two minimum forms and an average form that this slice does not implement. For those words the unit raises a separate "recognised, not implemented" flag, so the issue logic can route them to another slice.

The datapath is purely combinational. A parameter can add one output register stage, which has an asynchronous active-low reset.

Top module: `absdiff_exec`

## Requirements
- R1: A word whose bits insn_i[31:26] equal 22 and whose bits insn_i[10:1] equal 10'b1011110110 is a hit: valid_o and rt_we_o are both 1.
- R2: On a hit, rt_o equals insn_i[25:21], ra_o equals insn_i[20:16] and rb_o equals insn_i[15:11].
- R3: On a hit with unequal operands, result_o is b_i − a_i modulo 2^XLEN when a_i is less than b_i as a signed number, and a_i − b_i modulo 2^XLEN otherwise. Examples: (1,2) gives 1; (all-ones,2) gives 3; (2,all-ones) gives 3.
- R4: On a hit with a_i equal to b_i, result_o is 0.
- R5: On a hit, cr0_we_o equals the record bit insn_i[0].
- R6: When cr0_we_o is 1, the bits of cr0_o are set as follows:
  - cr0_o[3] is 1 when the result is negative as a signed number.
  - cr0_o[2] is 1 when the result is positive and nonzero.
  - cr0_o[1] is 1 when the result is zero.
  - cr0_o[0] equals so_i.
  - Exactly one of cr0_o[3:1] is 1.
- R7: Any word that is not a hit drives valid_o, rt_we_o and cr0_we_o to 0.
- R8: unimpl_o is 1 exactly when insn_i[31:26] is 22 and insn_i[10:1] is one of 10'b0101001110, 10'b0001001110 or 10'b1101001110. It is never 1 together with valid_o.
- R9: With REG_OUT=1, every output shows the inputs of the previous rising clock edge. While rst_ni is low, every output is 0. With REG_OUT=0, the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_i | input | 32 | Instruction word |
| a_i | input | XLEN | Value of the first source register |
| b_i | input | XLEN | Value of the second source register |
| so_i | input | 1 | Summary-overflow bit, copied into the condition field |
| valid_o | output | 1 | Word is the absolute-difference instruction |
| unimpl_o | output | 1 | Word is a recognised min/average form not handled here |
| rt_o | output | 5 | Destination register index |
| ra_o | output | 5 | First source register index |
| rb_o | output | 5 | Second source register index |
| rt_we_o | output | 1 | Destination write enable |
| result_o | output | XLEN | Absolute difference |
| cr0_o | output | 4 | Condition field {neg, pos, zero, so} |
| cr0_we_o | output | 1 | Condition field write enable |

## Verification
The checker assumes that rst_ni is held low for at least one clock edge before the first instruction, and that insn_i, a_i, b_i and so_i are stable around each rising edge. The bench meets both conditions: it keeps reset low for several cycles and changes every input only on the falling edge. The operand checks that look one cycle back also assume that the inputs seen at the previous edge are the ones now registered. This holds because the bench issues exactly one instruction per cycle with no gaps.

// File: rtl/absdiff_pkg.sv
package absdiff_pkg;
   localparam int INSN_W  = 32;
   localparam int RIDX_W  = 5;
   localparam int PO_W    = 6;
   localparam int XO_W    = 10;

   // Field positions, LSB-numbered within the 32-bit word
   localparam int PO_LSB  = 26;
   localparam int RT_LSB  = 21;
   localparam int RA_LSB  = 16;
   localparam int RB_LSB  = 11;
   localparam int XO_LSB  = 1;
   localparam int REC_POS = 0;

   localparam logic [PO_W-1:0] PO_GROUP   = 6'd22;
   localparam logic [XO_W-1:0] XO_ABSDIFF = 10'b1011110110;

   localparam int N_UNIMPL = 3;
   localparam logic [XO_W-1:0] XO_UNIMPL [N_UNIMPL] = '{
      10'b0101001110,   // signed minimum
      10'b0001001110,   // unsigned minimum
      10'b1101001110    // average
   };

   typedef struct packed {
      logic neg;
      logic pos;
      logic zero;
      logic so;
   } cond_t;

   typedef struct packed {
      logic              hit;
      logic              unimpl;
      logic              rec;
      logic [RIDX_W-1:0] rt;
      logic [RIDX_W-1:0] ra;
      logic [RIDX_W-1:0] rb;
   } dec_t;
endpackage

// File: rtl/absdiff_decode.sv
module absdiff_decode
   import absdiff_pkg::*;
(
   input  logic [INSN_W-1:0] insn_i,
   output dec_t              dec_o
);
   logic [PO_W-1:0]     po;
   logic [XO_W-1:0]     xo;
   logic                grp;
   logic [N_UNIMPL-1:0] un_hit;

   assign po  = insn_i[PO_LSB +: PO_W];
   assign xo  = insn_i[XO_LSB +: XO_W];
   assign grp = (po == PO_GROUP);

   for (genvar k = 0; k < N_UNIMPL; k++) begin : g_unimpl
      assign un_hit[k] = (xo == XO_UNIMPL[k]);
   end

   always_comb begin
      dec_o        = '0;
      dec_o.hit    = grp && (xo == XO_ABSDIFF);
      dec_o.unimpl = grp && (|un_hit);
      dec_o.rec    = insn_i[REC_POS];
      dec_o.rt     = insn_i[RT_LSB +: RIDX_W];
      dec_o.ra     = insn_i[RA_LSB +: RIDX_W];
      dec_o.rb     = insn_i[RB_LSB +: RIDX_W];
   end
endmodule

// File: rtl/absdiff_core.sv
module absdiff_core #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic [XLEN-1:0] res_o
);
   localparam int SUM_W = XLEN + 1;

   logic            a_lt_b;
   logic [XLEN-1:0] small_op;
   logic [XLEN-1:0] large_op;
   logic [SUM_W-1:0] sum;

   assign a_lt_b   = $signed(a_i) < $signed(b_i);
   assign small_op = a_lt_b ? a_i : b_i;
   assign large_op = a_lt_b ? b_i : a_i;

   // complement of the smaller plus the larger, carry-in of one
   assign sum   = {1'b0, ~small_op} + {1'b0, large_op} + SUM_W'(1);
   assign res_o = sum[XLEN-1:0];
endmodule

// File: rtl/absdiff_cond.sv
module absdiff_cond
   import absdiff_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] res_i,
   input  logic            so_i,
   output cond_t           cond_o
);
   logic is_zero;
   logic is_neg;

   assign is_zero = (res_i == '0);
   assign is_neg  = res_i[XLEN-1];

   always_comb begin
      cond_o.neg  = is_neg;
      cond_o.zero = is_zero;
      cond_o.pos  = !is_neg && !is_zero;
      cond_o.so   = so_i;
   end
endmodule

// File: rtl/absdiff_exec.sv
module absdiff_exec
   import absdiff_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [31:0]       insn_i,
   input  logic [XLEN-1:0]   a_i,
   input  logic [XLEN-1:0]   b_i,
   input  logic              so_i,
   output logic              valid_o,
   output logic              unimpl_o,
   output logic [4:0]        rt_o,
   output logic [4:0]        ra_o,
   output logic [4:0]        rb_o,
   output logic              rt_we_o,
   output logic [XLEN-1:0]   result_o,
   output logic [3:0]        cr0_o,
   output logic              cr0_we_o
);
   localparam int COND_W = $bits(cond_t);

   if (XLEN < 8 || (XLEN % 8) != 0) begin : g_bad_xlen
      $error("absdiff_exec: XLEN must be a multiple of 8, at least 8");
   end
   if (COND_W != 4) begin : g_bad_cond
      $error("absdiff_exec: condition field must be 4 bits");
   end

   dec_t            dec;
   logic [XLEN-1:0] diff;
   cond_t           cond;

   absdiff_decode u_dec (
      .insn_i (insn_i),
      .dec_o  (dec)
   );

   absdiff_core #(.XLEN(XLEN)) u_core (
      .a_i   (a_i),
      .b_i   (b_i),
      .res_o (diff)
   );

   absdiff_cond #(.XLEN(XLEN)) u_cond (
      .res_i  (diff),
      .so_i   (so_i),
      .cond_o (cond)
   );

   // next-state bundle of the output stage
   logic              n_valid, n_unimpl, n_rtwe, n_crwe;
   logic [4:0]        n_rt, n_ra, n_rb;
   logic [XLEN-1:0]   n_res;
   logic [3:0]        n_cr;

   always_comb begin
      n_valid  = dec.hit;
      n_unimpl = dec.unimpl;
      n_rtwe   = dec.hit;
      n_crwe   = dec.hit && dec.rec;
      n_rt     = dec.rt;
      n_ra     = dec.ra;
      n_rb     = dec.rb;
      n_res    = diff;
      n_cr     = cond;
   end

   if (REG_OUT) begin : g_reg
      logic              q_valid, q_unimpl, q_rtwe, q_crwe;
      logic [4:0]        q_rt, q_ra, q_rb;
      logic [XLEN-1:0]   q_res;
      logic [3:0]        q_cr;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            q_valid  <= 1'b0;
            q_unimpl <= 1'b0;
            q_rtwe   <= 1'b0;
            q_crwe   <= 1'b0;
            q_rt     <= '0;
            q_ra     <= '0;
            q_rb     <= '0;
            q_res    <= '0;
            q_cr     <= '0;
         end else begin
            q_valid  <= n_valid;
            q_unimpl <= n_unimpl;
            q_rtwe   <= n_rtwe;
            q_crwe   <= n_crwe;
            q_rt     <= n_rt;
            q_ra     <= n_ra;
            q_rb     <= n_rb;
            q_res    <= n_res;
            q_cr     <= n_cr;
         end
      end

      assign valid_o  = q_valid;
      assign unimpl_o = q_unimpl;
      assign rt_we_o  = q_rtwe;
      assign cr0_we_o = q_crwe;
      assign rt_o     = q_rt;
      assign ra_o     = q_ra;
      assign rb_o     = q_rb;
      assign result_o = q_res;
      assign cr0_o    = q_cr;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign valid_o  = n_valid;
      assign unimpl_o = n_unimpl;
      assign rt_we_o  = n_rtwe;
      assign cr0_we_o = n_crwe;
      assign rt_o     = n_rt;
      assign ra_o     = n_ra;
      assign rb_o     = n_rb;
      assign result_o = n_res;
      assign cr0_o    = n_cr;
   end
endmodule

// File: rtl/absdiff_exec_chk.sv
module absdiff_exec_chk #(
   parameter int XLEN    = 64,
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic            so_i,
   input  logic            valid_o,
   input  logic            unimpl_o,
   input  logic            rt_we_o,
   input  logic [XLEN-1:0] result_o,
   input  logic [3:0]      cr0_o,
   input  logic            cr0_we_o
);
   AST_WE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rt_we_o || cr0_we_o) |-> valid_o);                                  // R7
   AST_VALID_WRITES_RT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> rt_we_o);                                                // R1
   AST_ONE_COND_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cr0_we_o |-> ($countones(cr0_o[3:1]) == 1));                         // R6
   AST_ZERO_FLAG_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cr0_we_o |-> (cr0_o[1] == (result_o == '0)));                        // R6
   AST_UNIMPL_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(valid_o && unimpl_o));                                             // R8

   if (REG_OUT) begin : g_seq
      logic armed_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) armed_q <= 1'b0;
         else         armed_q <= 1'b1;
      end
      AST_EQUAL_GIVES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (armed_q && valid_o && ($past(a_i) == $past(b_i))) |-> (result_o == '0)); // R4
      AST_SO_COPIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (armed_q && cr0_we_o) |-> (cr0_o[0] == $past(so_i)));             // R9
   end else begin : g_comb
      AST_EQUAL_GIVES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (valid_o && (a_i == b_i)) |-> (result_o == '0));                   // R4
      AST_SO_COPIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
         cr0_we_o |-> (cr0_o[0] == so_i));                                  // R6
   end
endmodule

bind absdiff_exec absdiff_exec_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .a_i      (a_i),
   .b_i      (b_i),
   .so_i     (so_i),
   .valid_o  (valid_o),
   .unimpl_o (unimpl_o),
   .rt_we_o  (rt_we_o),
   .result_o (result_o),
   .cr0_o    (cr0_o),
   .cr0_we_o (cr0_we_o)
);

// File: tb/absdiff_exec_test.sv
module absdiff_exec_test;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 64;
   localparam logic [9:0] XO_ABS = 10'b1011110110;

   logic            clk = 1'b0;
   logic            rst_ni = 1'b0;
   logic [31:0]     insn = '0;
   logic [XLEN-1:0] a = '0, b = '0;
   logic            so = 1'b0;
   logic            valid, unimpl, rtwe, crwe;
   logic [4:0]      rt, ra, rb;
   logic [XLEN-1:0] res;
   logic [3:0]      cr;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   typedef struct {
      bit              v, un, crwe;
      bit [4:0]        rt, ra, rb;
      bit [XLEN-1:0]   res;
      bit [3:0]        cr;
      bit              eq_ops;
   } exp_t;
   exp_t pend[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   absdiff_exec #(.XLEN(XLEN), .REG_OUT(1'b1)) uut (
      .clk_i(clk), .rst_ni(rst_ni), .insn_i(insn), .a_i(a), .b_i(b), .so_i(so),
      .valid_o(valid), .unimpl_o(unimpl), .rt_o(rt), .ra_o(ra), .rb_o(rb),
      .rt_we_o(rtwe), .result_o(res), .cr0_o(cr), .cr0_we_o(crwe)
   );

   task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit [5:0] po, input bit [9:0] xo, input bit rec,
                                      input bit [4:0] t, input bit [4:0] s1, input bit [4:0] s2);
      return {po, t, s1, s2, xo, rec};
   endfunction

   function automatic exp_t model(input logic [31:0] w, input logic [XLEN-1:0] x,
                                  input logic [XLEN-1:0] y, input logic s);
      exp_t e;
      longint sx, sy, sr;
      sx = x; sy = y;
      e.v  = (w[31:26] == 6'd22) && (w[10:1] == XO_ABS);
      e.un = (w[31:26] == 6'd22) && (w[10:1] == 10'b0101001110 ||
             w[10:1] == 10'b0001001110 || w[10:1] == 10'b1101001110);
      e.crwe = e.v && w[0];
      e.rt = w[25:21]; e.ra = w[20:16]; e.rb = w[15:11];
      e.res = (sx < sy) ? (y - x) : (x - y);
      sr = e.res;
      e.cr = {sr < 0, sr > 0, sr == 0, s};
      e.eq_ops = (x == y);
      return e;
   endfunction

   task automatic compare_front();
      exp_t e;
      if (pend.size() == 0) return;
      e = pend.pop_front();
      chk("R1 R7 valid_o", valid, e.v);
      chk("R1 R7 rt_we_o", rtwe, e.v);
      chk("R5 R7 cr0_we_o", crwe, e.crwe);
      chk("R8 unimpl_o", unimpl, e.un);
      if (e.v) begin
         chk("R2 rt_o", rt, e.rt);
         chk("R2 ra_o", ra, e.ra);
         chk("R2 rb_o", rb, e.rb);
         if (e.eq_ops) chk("R4 result_o", res, e.res);
         else          chk("R3 R9 result_o", res, e.res);
         if (e.crwe) chk("R6 cr0_o", cr, e.cr);
      end
   endtask

   task automatic step(input logic [31:0] w, input logic [XLEN-1:0] x,
                       input logic [XLEN-1:0] y, input logic s);
      @(negedge clk);
      compare_front();
      insn = w; a = x; b = y; so = s;
      pend.push_back(model(w, x, y, s));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      logic [XLEN-1:0] ones, maxp, minn;
      ones = '1;
      maxp = {1'b0, {(XLEN-1){1'b1}}};
      minn = {1'b1, {(XLEN-1){1'b0}}};
      insn = mk(6'd22, XO_ABS, 1'b1, 5'd3, 5'd1, 5'd2);
      a = 64'd7; b = 64'd9;
      repeat (3) @(negedge clk);
      // R9: outputs held at zero during reset
      chk("R9 reset valid_o", valid, 0);
      chk("R9 reset cr0_we_o", crwe, 0);
      chk("R9 reset result_o", res, 0);
      chk("R9 reset unimpl_o", unimpl, 0);
      rst_ni = 1'b1;

      step(mk(6'd22, XO_ABS, 0, 5'd3, 5'd1, 5'd2), 64'd1, 64'd2, 0);
      step(mk(6'd22, XO_ABS, 0, 5'd3, 5'd1, 5'd2), ones, 64'd2, 0);
      step(mk(6'd22, XO_ABS, 1, 5'd3, 5'd1, 5'd2), 64'd2, ones, 1);
      step(mk(6'd22, XO_ABS, 1, 5'd31, 5'd0, 5'd17), 64'd5, 64'd5, 0);
      step(mk(6'd22, XO_ABS, 1, 5'd8, 5'd9, 5'd10), 64'd5, 64'd5, 1);
      step(mk(6'd22, XO_ABS, 1, 5'd4, 5'd5, 5'd6), maxp, minn, 0);
      step(mk(6'd22, XO_ABS, 1, 5'd4, 5'd6, 5'd5), minn, maxp, 1);
      step(mk(6'd22, XO_ABS, 1, 5'd1, 5'd2, 5'd3), 64'd100, 64'd40, 0);
      step(mk(6'd22, XO_ABS, 0, 5'd1, 5'd2, 5'd3), 64'd40, 64'd100, 1);
      // R7: near-miss encodings
      step(mk(6'd23, XO_ABS, 1, 5'd1, 5'd2, 5'd3), 64'd1, 64'd9, 1);
      step(mk(6'd22, XO_ABS ^ 10'd1, 1, 5'd1, 5'd2, 5'd3), 64'd1, 64'd9, 1);
      step(mk(6'd31, XO_ABS, 0, 5'd1, 5'd2, 5'd3), 64'd1, 64'd9, 0);
      // R8: sibling encodings
      step(mk(6'd22, 10'b0101001110, 1, 5'd1, 5'd2, 5'd3), 64'd1, 64'd9, 0);
      step(mk(6'd22, 10'b0001001110, 0, 5'd1, 5'd2, 5'd3), 64'd1, 64'd9, 0);
      step(mk(6'd22, 10'b1101001110, 1, 5'd1, 5'd2, 5'd3), 64'd1, 64'd9, 0);
      step(mk(6'd30, 10'b1101001110, 1, 5'd1, 5'd2, 5'd3), 64'd1, 64'd9, 0);

      for (int i = 0; i < 300; i++) begin
         logic [31:0] w;
         logic [XLEN-1:0] x, y;
         w = mk(6'd22, XO_ABS, 1'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
         if ((i % 7) == 0) w = $urandom;
         x = {$urandom, $urandom};
         y = ((i % 11) == 0) ? x : {$urandom, $urandom};
         if ((i % 5) == 0) y = {1'b0, y[XLEN-2:0]} >> (i % 60);
         step(w, x, y, 1'($urandom));
      end
      @(negedge clk);
      compare_front();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule